// File: doc/BRIEF.md
# Command/Response Ring Pointer Engine

This block keeps the queue state of a two-port DMA command engine on the register side of a 32-bit memory-mapped bus. Each port owns two 32-entry rings: a request ring that software fills, and a response ring in which the engine posts completions. Four pointers per port record the ring state: request in, request out, response in and response out. All pointers wrap modulo the ring depth. Software produces work by moving the request in-pointer forward and retires completions by moving the response out-pointer forward. A one-cycle consume strobe per port stands in for the engine. Each accepted strobe takes one request and posts one response.

Each port has a command word with enable, self-clearing disable and channel reset controls, and a sticky overflow flag that records a rejected request. Completions set bits in one cause register shared by both ports, and that register drives a level interrupt. Per-port registers occupy a 64-byte window at byte address `port*0x40`. The word offsets are: 0x00 command, 0x04 request in, 0x08 request out, 0x0C response in, 0x10 response out, 0x14 status. The shared cause register sits at 0x80. Any other address reads as zero.

Top module: `dma_ring_ptr_engine`

## Requirements
- R1: After reset, every register of both ports reads 0, the cause register reads 0 and `irq_o` is low.
- R2: The request pointers sit in bits 9:5. The request in-pointer word also stores ring base bits 31:10 and reads bits 4:0 as zero. The request out-pointer word reads only bits 9:5, and every other bit reads zero.
- R3: The response pointers sit in bits 7:3. The response out-pointer word also stores ring base bits 31:8 and reads bits 2:0 as zero. The response in-pointer word reads only bits 7:3, and every other bit reads zero.
- R4: In the command word, writing 1 to bit 0 sets the enable and writing 0 to bit 0 leaves it unchanged. Writing 1 to bit 1 clears the enable and wins over bit 0 in the same write. Bit 1 always reads 0. The command word reads the enable at bit 0.
- R5: Writing 1 to command bit 2 starts a channel reset, and the bit reads back 1 until software writes it to 0. While the reset is in force, all four pointers, the enable and the overflow flag read 0, and pointer writes are ignored. Ring base bits keep their values.
- R6: A consume strobe is accepted only when the port is enabled, the request ring is not empty (in differs from out) and the response ring is not full (response in plus one differs from response out). An accepted strobe advances the request out-pointer and the response in-pointer by one in the next cycle. A strobe that is not accepted changes nothing.
- R7: Every pointer advance wraps from 31 to 0.
- R8: While a port is disabled, writes load any of its four pointer fields directly. While it is enabled, writes to the request out-pointer and the response in-pointer are ignored.
- R9: While enabled, a request in-pointer write is ignored if the new value differs from the current value and equals the request out-pointer, because that would fill the ring. Such a write sets the overflow flag (status bit 0). The flag stays set until a channel reset.
- R10: In the cause register, bit p (p = 0 or 1) is set by an accepted consume on port p. Bit 8+p is set when that consume empties the port's request ring. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A set in the same cycle wins over a clear. `irq_o` is high whenever any cause bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| consume_i | input | 2 | Per-port engine consume strobe |
| irq_o | output | 1 | Completion interrupt, OR of all cause bits |

## Verification
The assertions assume three things about the inputs. A consume strobe and a register write never target the same port in the same cycle. Channel reset is entered only by a command write. Addresses are word aligned. The bench follows all three: it drives each write or each strobe for exactly one cycle, one operation at a time. The random mix of strobes, pointer advances, command writes and cause writes runs against a bench model, and the full register file of the touched port is compared after every operation.

// File: rtl/ring_eng_pkg.sv
package ring_eng_pkg;
  typedef enum logic [2:0] {
    OFF_CMD    = 3'd0,
    OFF_RQ_IN  = 3'd1,
    OFF_RQ_OUT = 3'd2,
    OFF_RS_IN  = 3'd3,
    OFF_RS_OUT = 3'd4,
    OFF_STAT   = 3'd5
  } reg_off_e;

  localparam int CMD_EN_BIT  = 0;
  localparam int CMD_DIS_BIT = 1;
  localparam int CMD_RST_BIT = 2;
  localparam int CAUSE_AUX_LSB = 8;
endpackage

// File: rtl/ring_chan.sv
module ring_chan
  import ring_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int RQ_LSB = 5,
  parameter int RS_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_off_e          off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              consume_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              drained_o
);
  localparam int PTR_W       = $clog2(DEPTH);
  localparam int RQ_BASE_LSB = RQ_LSB + PTR_W;
  localparam int RS_BASE_LSB = RS_LSB + PTR_W;

  logic en_q, rst_q, ovf_q;
  logic [PTR_W-1:0] rq_in_q, rq_out_q, rs_in_q, rs_out_q;
  logic [DATA_W-1:RQ_BASE_LSB] rq_base_q;
  logic [DATA_W-1:RS_BASE_LSB] rs_base_q;

  logic wr_cmd, wr_rq_in, wr_rq_out, wr_rs_in, wr_rs_out, rst_eff;
  logic [PTR_W-1:0] w_rq, w_rs, rq_out_nxt, rs_in_nxt, lag;
  logic rq_empty, rs_full, fire, rq_fill_wr;

  assign wr_cmd    = wr_i && (off_i == OFF_CMD);
  assign wr_rq_in  = wr_i && (off_i == OFF_RQ_IN);
  assign wr_rq_out = wr_i && (off_i == OFF_RQ_OUT);
  assign wr_rs_in  = wr_i && (off_i == OFF_RS_IN);
  assign wr_rs_out = wr_i && (off_i == OFF_RS_OUT);
  // a command write decides the reset level, otherwise the held bit does
  assign rst_eff   = wr_cmd ? wdata_i[CMD_RST_BIT] : rst_q;

  assign w_rq       = wdata_i[RQ_LSB +: PTR_W];
  assign w_rs       = wdata_i[RS_LSB +: PTR_W];
  assign rq_out_nxt = rq_out_q + 1'b1;
  assign rs_in_nxt  = rs_in_q + 1'b1;
  assign lag        = rq_out_q - rs_in_q;

  assign rq_empty   = (rq_in_q == rq_out_q);
  assign rs_full    = (rs_in_nxt == rs_out_q);
  assign fire       = consume_i && en_q && !rq_empty && !rs_full && !rst_eff;
  assign rq_fill_wr = (w_rq != rq_in_q) && (w_rq == rq_out_q);

  assign done_o     = fire;
  assign drained_o  = fire && (rq_out_nxt == rq_in_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      rst_q     <= 1'b0;
      ovf_q     <= 1'b0;
      rq_in_q   <= '0;
      rq_out_q  <= '0;
      rs_in_q   <= '0;
      rs_out_q  <= '0;
      rq_base_q <= '0;
      rs_base_q <= '0;
    end else begin
      if (wr_cmd)    rst_q     <= wdata_i[CMD_RST_BIT];
      if (wr_rq_in)  rq_base_q <= wdata_i[DATA_W-1:RQ_BASE_LSB];
      if (wr_rs_out) rs_base_q <= wdata_i[DATA_W-1:RS_BASE_LSB];
      if (rst_eff) begin
        en_q     <= 1'b0;
        ovf_q    <= 1'b0;
        rq_in_q  <= '0;
        rq_out_q <= '0;
        rs_in_q  <= '0;
        rs_out_q <= '0;
      end else begin
        if (wr_cmd) begin
          if (wdata_i[CMD_DIS_BIT])     en_q <= 1'b0;
          else if (wdata_i[CMD_EN_BIT]) en_q <= 1'b1;
        end
        if (wr_rq_in) begin
          if (en_q && rq_fill_wr) ovf_q   <= 1'b1;
          else                    rq_in_q <= w_rq;
        end
        if (wr_rq_out && !en_q) rq_out_q <= w_rq;
        else if (fire)          rq_out_q <= rq_out_nxt;
        if (wr_rs_in && !en_q)  rs_in_q  <= w_rs;
        else if (fire)          rs_in_q  <= rs_in_nxt;
        if (wr_rs_out)          rs_out_q <= w_rs;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      OFF_CMD: begin
        rdata_o[CMD_EN_BIT]  = en_q;
        rdata_o[CMD_RST_BIT] = rst_q;
      end
      OFF_RQ_IN: begin
        rdata_o[RQ_LSB +: PTR_W]             = rq_in_q;
        rdata_o[DATA_W-1:RQ_BASE_LSB]        = rq_base_q;
      end
      OFF_RQ_OUT: rdata_o[RQ_LSB +: PTR_W]   = rq_out_q;
      OFF_RS_IN:  rdata_o[RS_LSB +: PTR_W]   = rs_in_q;
      OFF_RS_OUT: begin
        rdata_o[RS_LSB +: PTR_W]             = rs_out_q;
        rdata_o[DATA_W-1:RS_BASE_LSB]        = rs_base_q;
      end
      OFF_STAT:   rdata_o[0]                 = ovf_q;
      default:    rdata_o = '0;
    endcase
  end

  // R6: while enabled, request-out and response-in move only together
  p_lockstep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !wr_i) |=> $stable(lag));

  // R8: nothing moves engine-owned pointers while disabled
  p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_i) |=> ($stable(rq_out_q) && $stable(rs_in_q)));

  // R9: an enabled producer write never fills the request ring
  p_no_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && wr_rq_in && !consume_i && (rq_in_q != rq_out_q)) |=> (rq_in_q != rq_out_q));

  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !wr_i) |=> ovf_q);

  // R5: held channel reset keeps the state cleared
  p_rst_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> (rq_in_q == '0 && rq_out_q == '0 && rs_in_q == '0 && rs_out_q == '0
               && !en_q && !ovf_q));

  // R4: disable write always leaves the engine off
  p_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wdata_i[CMD_DIS_BIT]) |=> !en_q);
endmodule

// File: rtl/ring_cause.sv
module ring_cause
  import ring_eng_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_PORTS-1:0] done_i,
  input  logic [NUM_PORTS-1:0] drained_i,
  output logic [DATA_W-1:0]    cause_o,
  output logic                 irq_o
);
  logic [NUM_PORTS-1:0] cmp_q, aux_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_q[p] <= 1'b0;
        aux_q[p] <= 1'b0;
      end else begin
        if (done_i[p])                              cmp_q[p] <= 1'b1;
        else if (wr_i && !wdata_i[p])               cmp_q[p] <= 1'b0;
        if (drained_i[p])                           aux_q[p] <= 1'b1;
        else if (wr_i && !wdata_i[CAUSE_AUX_LSB+p]) aux_q[p] <= 1'b0;
      end
    end

    // R10: a completion set is never lost to a same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[p] |=> cmp_q[p]);
    p_aux_needs_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drained_i[p] |-> done_i[p]);
  end

  always_comb begin
    cause_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      cause_o[p]               = cmp_q[p];
      cause_o[CAUSE_AUX_LSB+p] = aux_q[p];
    end
  end

  assign irq_o = |{cmp_q, aux_q};

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/dma_ring_ptr_engine.sv
module dma_ring_ptr_engine
  import ring_eng_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int RING_DEPTH = 32,
  parameter int RQ_PTR_LSB = 5,
  parameter int RS_PTR_LSB = 3,
  parameter int CH_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter int ADDR_W     = 7 + CH_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_PORTS-1:0] consume_i,
  output logic                 irq_o
);
  localparam int DATA_W = 32;

  logic            cause_hit, chan_hit;
  logic [CH_W-1:0] ch_idx;
  reg_off_e        off;
  logic [DATA_W-1:0]    ch_rdata [NUM_PORTS];
  logic [NUM_PORTS-1:0] done, drained;
  logic [DATA_W-1:0]    cause_word;

  assign cause_hit = reg_addr_i[ADDR_W-1] && (reg_addr_i[ADDR_W-2:2] == '0);
  assign chan_hit  = !reg_addr_i[ADDR_W-1] && !reg_addr_i[5];
  assign ch_idx    = reg_addr_i[6 +: CH_W];
  assign off       = reg_off_e'(reg_addr_i[4:2]);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chan
    ring_chan #(
      .DATA_W (DATA_W),
      .DEPTH  (RING_DEPTH),
      .RQ_LSB (RQ_PTR_LSB),
      .RS_LSB (RS_PTR_LSB)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_we_i && chan_hit && (ch_idx == CH_W'(p))),
      .off_i     (off),
      .wdata_i   (reg_wdata_i),
      .consume_i (consume_i[p]),
      .rdata_o   (ch_rdata[p]),
      .done_o    (done[p]),
      .drained_o (drained[p])
    );
  end

  ring_cause #(
    .DATA_W    (DATA_W),
    .NUM_PORTS (NUM_PORTS)
  ) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_we_i && cause_hit),
    .wdata_i   (reg_wdata_i),
    .done_i    (done),
    .drained_i (drained),
    .cause_o   (cause_word),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (cause_hit) reg_rdata_o = cause_word;
    else if (chan_hit) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (ch_idx == CH_W'(p)) reg_rdata_o = ch_rdata[p];
    end
  end

  logic unused_addr;
  assign unused_addr = ^reg_addr_i[1:0];

  // R10: interrupt follows the cause word
  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (cause_word != '0));
endmodule

// File: tb/tb_dma_ring_ptr_engine.sv
module tb_dma_ring_ptr_engine;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] cons = '0;
  logic        irq;

  dma_ring_ptr_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .consume_i(cons), .irq_o(irq)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done_flag = 1'b0;

  int m_rqi[NP], m_rqo[NP], m_rsi[NP], m_rso[NP];
  bit m_en[NP], m_rst[NP], m_ovf[NP], m_cmp[NP], m_aux[NP];
  logic [31:0] m_rqb[NP], m_rsb[NP];

  function automatic void m_clear();
    for (int p = 0; p < NP; p++) begin
      m_rqi[p] = 0; m_rqo[p] = 0; m_rsi[p] = 0; m_rso[p] = 0;
      m_en[p] = 0; m_rst[p] = 0; m_ovf[p] = 0; m_cmp[p] = 0; m_aux[p] = 0;
      m_rqb[p] = '0; m_rsb[p] = '0;
    end
  endfunction

  function automatic void m_write(logic [7:0] a, logic [31:0] d);
    int p, off, w;
    if (a == 8'h80) begin
      for (int q = 0; q < NP; q++) begin
        if (!d[q])   m_cmp[q] = 0;
        if (!d[8+q]) m_aux[q] = 0;
      end
      return;
    end
    if (a[7] || a[5]) return;
    p = int'(a[6]);
    off = int'(a[4:2]);
    case (off)
      0: begin
        if (d[2]) begin
          m_rst[p] = 1; m_en[p] = 0; m_ovf[p] = 0;
          m_rqi[p] = 0; m_rqo[p] = 0; m_rsi[p] = 0; m_rso[p] = 0;
        end else begin
          m_rst[p] = 0;
          if (d[1]) m_en[p] = 0;
          else if (d[0]) m_en[p] = 1;
        end
      end
      1: begin
        m_rqb[p] = d & 32'hFFFF_FC00;
        w = int'(d[9:5]);
        if (!m_rst[p]) begin
          if (m_en[p] && w != m_rqi[p] && w == m_rqo[p]) m_ovf[p] = 1;
          else m_rqi[p] = w;
        end
      end
      2: if (!m_rst[p] && !m_en[p]) m_rqo[p] = int'(d[9:5]);
      3: if (!m_rst[p] && !m_en[p]) m_rsi[p] = int'(d[7:3]);
      4: begin
        m_rsb[p] = d & 32'hFFFF_FF00;
        if (!m_rst[p]) m_rso[p] = int'(d[7:3]);
      end
      default: ;
    endcase
  endfunction

  function automatic void m_consume(int p);
    if (m_en[p] && m_rqi[p] != m_rqo[p] && ((m_rsi[p] + 1) % 32) != m_rso[p]) begin
      m_rqo[p] = (m_rqo[p] + 1) % 32;
      m_rsi[p] = (m_rsi[p] + 1) % 32;
      m_cmp[p] = 1;
      if (m_rqo[p] == m_rqi[p]) m_aux[p] = 1;
    end
  endfunction

  function automatic logic [31:0] exp_reg(int p, int off);
    case (off)
      0: return {29'b0, m_rst[p], 1'b0, m_en[p]};
      1: return m_rqb[p] | (32'(m_rqi[p]) << 5);
      2: return 32'(m_rqo[p]) << 5;
      3: return 32'(m_rsi[p]) << 3;
      4: return m_rsb[p] | (32'(m_rso[p]) << 3);
      5: return {31'b0, m_ovf[p]};
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] exp_cause();
    logic [31:0] c = '0;
    for (int q = 0; q < NP; q++) begin
      c[q] = m_cmp[q];
      c[8+q] = m_aux[q];
    end
    return c;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_port(int p, string tag);
    logic [31:0] v;
    for (int off = 0; off < 6; off++) begin
      rd(8'(p * 64 + off * 4), v);
      chk(tag, $sformatf("port%0d reg%0d", p, off), v, exp_reg(p, off));
    end
    rd(8'h80, v);
    chk(tag, "cause", v, exp_cause());
    chk(tag, "irq", {31'b0, irq}, {31'b0, exp_cause() != 0});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    m_write(a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cons_p(int p);
    @(negedge clk);
    cons[p] = 1'b1;
    m_consume(p);
    @(negedge clk);
    cons = '0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, r, nv;
    logic [7:0] b;
    void'($urandom(32'h00C0FFEE));
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_port(0, "R1");
    check_port(1, "R1");

    // R2 / R3 / R8: field placement, direct loads while disabled
    wr(8'h04, 32'hABCD_E7FF); wr(8'h08, 32'h1234_5677);
    check_port(0, "R2");
    wr(8'h0C, 32'h5A5A_A5FF); wr(8'h10, 32'hFFFF_FFFF);
    check_port(0, "R3");
    check_port(0, "R8");

    // R5: channel reset
    wr(8'h00, 32'h4); check_port(0, "R5");
    wr(8'h04, 32'h0000_0460); check_port(0, "R5");
    wr(8'h00, 32'h0); check_port(0, "R5");

    // R4: command bits
    wr(8'h00, 32'h1); check_port(0, "R4");
    wr(8'h00, 32'h0); check_port(0, "R4");
    wr(8'h00, 32'h2); check_port(0, "R4");
    wr(8'h00, 32'h3); check_port(0, "R4");
    wr(8'h00, 32'h1);

    // R6: consume on empty ring, then three requests
    cons_p(0); check_port(0, "R6");
    wr(8'h04, 32'(3) << 5);
    for (int i = 0; i < 3; i++) begin cons_p(0); check_port(0, "R6"); end
    // R10: selective clears
    wr(8'h80, 32'hFFFF_FEFF); check_port(0, "R10");
    wr(8'h80, 32'h0); check_port(0, "R10");

    // R8: engine-owned pointers locked while enabled
    wr(8'h08, 32'(7) << 5); wr(8'h0C, 32'(9) << 3);
    check_port(0, "R8");

    // R7: wrap through 31
    wr(8'h00, 32'h2);
    wr(8'h08, 32'(30) << 5); wr(8'h0C, 32'(30) << 3);
    wr(8'h10, 32'(30) << 3); wr(8'h04, 32'(1) << 5);
    wr(8'h00, 32'h1);
    for (int i = 0; i < 3; i++) begin cons_p(0); check_port(0, "R7"); end

    // R9: fill attempt and sticky overflow
    wr(8'h04, 32'h0); check_port(0, "R9");
    wr(8'h04, 32'(1) << 5); check_port(0, "R9");
    cons_p(0); check_port(0, "R9");
    wr(8'h00, 32'h4); check_port(0, "R9");
    wr(8'h00, 32'h0);

    // R6: response ring full blocks port 1
    wr(8'h44, 32'(2) << 5); wr(8'h50, 32'(1) << 3);
    wr(8'h40, 32'h1);
    cons_p(1); check_port(1, "R6");
    wr(8'h50, 32'(5) << 3);
    cons_p(1); check_port(1, "R6");
    check_port(1, "R10");

    // random mix
    for (int it = 0; it < 400; it++) begin
      p = int'($urandom_range(0, NP - 1));
      b = 8'(p * 64);
      r = int'($urandom_range(0, 9));
      case (r)
        0, 1, 2, 3: begin cons_p(p); check_port(p, "R6"); end
        4, 5: begin
          nv = (m_rqi[p] + int'($urandom_range(1, 3))) % 32;
          wr(b + 8'h04, ($urandom & 32'hFFFF_FC00) | (32'(nv) << 5));
          check_port(p, "R9");
        end
        6: begin
          if (m_rso[p] != m_rsi[p]) begin
            nv = (m_rso[p] + 1) % 32;
            wr(b + 8'h10, ($urandom & 32'hFFFF_FF00) | (32'(nv) << 3));
          end
          check_port(p, "R3");
        end
        7: begin wr(b, 32'($urandom_range(0, 3))); check_port(p, "R4"); end
        8: begin
          if (m_en[p]) begin
            wr(b, 32'h4); check_port(p, "R5"); wr(b, 32'h1);
          end else begin
            wr(b + 8'h08, $urandom); wr(b + 8'h0C, $urandom);
            check_port(p, "R8");
          end
        end
        default: begin wr(8'h80, $urandom); check_port(p, "R10"); end
      endcase
    end
    finish_run();
  end
endmodule